// File: doc/BRIEF.md
# Burst-of-Four SRAM Read Port

This block models the read side of a separate-port, double-data-rate SRAM whose accesses always move four words. A single double-rate clock `clk` drives the model. Each of its edges is one data beat, so two beats make one cycle of the original input clock. An internal phase bit marks which beats line up with a rising edge of that slower clock. The first edge after reset is release is such a rising-phase edge, and after that the rising-phase edges are every other edge.

A read request sampled on a rising-phase edge captures a row address. The four words of that row are then returned on `q_data`, one per beat, lowest-order word first. Each word comes from one of four storage banks. A request on the rising edge straight after an accepted one is dropped, so bursts issued on every other rising edge join into a continuous stream. A strap input selects a first-word latency of one or one-and-a-half input-clock cycles. After the last burst drains, an output-enable flag releases the bus at the next rising-phase edge. A simple load port fills the banks, because this model has no write path of its own.

Top module: `brd_read_port`

## Requirements
- R1: A request is accepted only when `rd_sel` is high on a rising-phase edge: the 1st, 3rd, 5th, ... edge after reset is released, counting from 1. `rd_sel` on the other edges has no effect.
- R2: An accepted request for row A returns four words on consecutive beats: the words at load address {A,0}, {A,1}, {A,2}, {A,3}, in that order. The two low bits of the load address are the word index.
- R3: A request on the rising-phase edge straight after an accepted request is ignored, and its address never appears. The next rising-phase edge after that can accept again.
- R4: With `rd_sel` held high, requests are accepted on every other rising-phase edge, and `q_valid` stays high without a gap.
- R5: With `lat_mode`=0, the first word is on the outputs after the 2nd edge following the accepting edge. With `lat_mode`=1, it is there after the 3rd edge. `lat_mode` changes only while `rst` is high.
- R6: `q_valid` is high exactly on beats that carry a burst word. On all other beats `q_data` is zero.
- R7: `rd_oe` is high on every valid beat. After the last valid beat, `rd_oe` stays high until the next rising-phase edge with no valid word to present, and it falls at that edge.
- R8: While `rst` is high, and right after it is released, `q_valid`, `q_data` and `rd_oe` are all zero.
- R9: When `ld_en` is high at an edge, `ld_data` is stored at `ld_addr`, in bank `ld_addr[1:0]`, row `ld_addr[AW+1:2]`. Loading does not depend on `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate beat clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_mode | input | 1 | 1: latency of 1.5 cycles, 0: latency of 1 cycle |
| rd_sel | input | 1 | Read request, sampled on rising-phase edges |
| rd_addr | input | AW | Row address of the request |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | AW+2 | Load word address {row, word index} |
| ld_data | input | DW | Load data |
| q_data | output | DW | Read data, zero when no word is presented |
| q_valid | output | 1 | Beat carries a burst word |
| rd_oe | output | 1 | Output-enable flag for the data bus |

## Verification
The bench goes after requests on consecutive rising-phase edges. A design that accepted the second request would splice a foreign row into the stream or cut the first burst short. It drives `rd_sel` only on falling-phase beats, which a phase-blind design would take as reads. It holds `rd_sel` high to check for gapless streaming, where an off-by-one in the beat sequencer would leave holes or repeat words. It also runs both latency straps, because a wrong pipeline depth shifts every word by a beat. In the longer latency, the release check catches a design that drops `rd_oe` together with `q_valid` instead of waiting for the rising-phase edge.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int BEATS = 4;
  localparam int BW    = $clog2(BEATS);
  typedef logic [BW-1:0] beat_t;
endpackage

// File: rtl/brd_bank.sv
module brd_bank #(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/brd_ctrl.sv
module brd_ctrl
  import brd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic          phase,
  output logic          iss_v,
  output beat_t         iss_beat,
  output logic [AW-1:0] iss_row
);
  logic last_acc;
  logic accept;

  assign accept = !phase && rd_sel && !last_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      last_acc <= 1'b0;
      iss_v    <= 1'b0;
      iss_beat <= '0;
      iss_row  <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) last_acc <= accept;
      if (accept) begin
        iss_row  <= rd_addr;
        iss_v    <= 1'b1;
        iss_beat <= '0;
      end else if (iss_v) begin
        iss_beat <= iss_beat + beat_t'(1);
        if (iss_beat == beat_t'(BEATS-1)) iss_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brd_outpipe.sv
module brd_outpipe
  import brd_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lat_mode,
  input  logic                   phase,
  input  logic                   iss_v,
  input  beat_t                  iss_beat,
  input  logic [BEATS-1:0][DW-1:0] bank_q,
  output logic [DW-1:0]          q_data,
  output logic                   q_valid,
  output logic                   rd_oe
);
  logic          s1_v, s2_v, s3_v;
  beat_t         s1_beat;
  logic [DW-1:0] s2_d, s3_d;
  logic          nxt_v;

  assign nxt_v = lat_mode ? s2_v : s1_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_beat <= '0;
      s2_v    <= 1'b0;
      s2_d    <= '0;
      s3_v    <= 1'b0;
      s3_d    <= '0;
      rd_oe   <= 1'b0;
    end else begin
      s1_v    <= iss_v;
      s1_beat <= iss_beat;
      s2_v    <= s1_v;
      s2_d    <= s1_v ? bank_q[s1_beat] : '0;
      s3_v    <= s2_v;
      s3_d    <= s2_d;
      if (nxt_v)       rd_oe <= 1'b1;
      else if (!phase) rd_oe <= 1'b0;
    end
  end

  assign q_valid = lat_mode ? s3_v : s2_v;
  assign q_data  = lat_mode ? s3_d : s2_d;
endmodule

// File: rtl/brd_read_port.sv
module brd_read_port
  import brd_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_mode,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  input  logic          ld_en,
  input  logic [AW+1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] q_data,
  output logic          q_valid,
  output logic          rd_oe
);
  logic                    phase;
  logic                    iss_v;
  beat_t                   iss_beat;
  logic [AW-1:0]           iss_row;
  logic [BEATS-1:0][DW-1:0] bank_q;

  brd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .phase(phase), .iss_v(iss_v), .iss_beat(iss_beat), .iss_row(iss_row)
  );

  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    brd_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk   (clk),
      .we    (ld_en && ld_addr[BW-1:0] == beat_t'(b)),
      .waddr (ld_addr[AW+BW-1:BW]),
      .wdata (ld_data),
      .re    (iss_v && iss_beat == beat_t'(b)),
      .raddr (iss_row),
      .rdata (bank_q[b])
    );
  end

  brd_outpipe #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .lat_mode(lat_mode), .phase(phase),
    .iss_v(iss_v), .iss_beat(iss_beat), .bank_q(bank_q),
    .q_data(q_data), .q_valid(q_valid), .rd_oe(rd_oe)
  );
endmodule

// File: rtl/brd_read_port_chk.sv
module brd_read_port_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          lat_mode,
  input logic [DW-1:0] q_data,
  input logic          q_valid,
  input logic          rd_oe
);
  logic       ck_ph;
  logic [1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_ph   <= 1'b0;
      run_cnt <= '0;
    end else begin
      ck_ph   <= ~ck_ph;
      run_cnt <= q_valid ? run_cnt + 2'd1 : 2'd0;
    end
  end

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> q_data == '0);

  // R7
  oe_cover_chk: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> rd_oe);

  // R7
  oe_release_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_oe) |-> $past(ck_ph) == 1'b0);

  // R5
  first_word_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q_valid) |-> $past(ck_ph) == lat_mode);

  // R2
  whole_burst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q_valid) |-> run_cnt == 2'd0);
endmodule

bind brd_read_port brd_read_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .lat_mode(lat_mode),
  .q_data(q_data), .q_valid(q_valid), .rd_oe(rd_oe)
);

// File: tb/tb_brd_read_port.sv
module tb_brd_read_port;
  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int NW = 1 << (AW + 2);
  localparam int NE = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lat_mode = 1'b0;
  logic          rd_sel = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          ld_en = 1'b0;
  logic [AW+1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] q_data;
  logic          q_valid;
  logic          rd_oe;

  brd_read_port #(.AW(AW), .DW(DW)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  logic [DW-1:0] sh [NW];
  logic          ev [NE];
  logic [DW-1:0] ed [NE];
  int  e, errors, checks;
  logic b_last, oe_prev;
  bit  done;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", tag, e, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] row, input int k);
    return sh[{row, 2'(k)}];
  endfunction

  task automatic do_reset(input logic lat);
    @(negedge clk);
    rst = 1'b1; rd_sel = 1'b0; lat_mode = lat;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NE; i++) begin ev[i] = 1'b0; ed[i] = '0; end
    e = 0; b_last = 1'b0; oe_prev = 1'b0;
    chk(q_valid == 1'b0, "R8 valid", DW'(q_valid), '0);
    chk(q_data == '0, "R8 data", q_data, '0);
    chk(rd_oe == 1'b0, "R8 oe", DW'(rd_oe), '0);
    rst = 1'b0;
  endtask

  task automatic step(input logic sel, input logic [AW-1:0] a, input string seg);
    logic acc;
    logic exp_oe;
    int lat;
    lat = lat_mode ? 3 : 2;
    rd_sel = sel; rd_addr = a;
    acc = (e % 2 == 0) && sel && !b_last;
    if (e % 2 == 0) b_last = acc;
    if (acc)
      for (int k = 0; k < 4; k++) begin
        ev[e+lat+k] = 1'b1;
        ed[e+lat+k] = exp_word(a, k);
      end
    @(posedge clk);
    @(negedge clk);
    exp_oe = ev[e] ? 1'b1 : ((e % 2 == 0) ? 1'b0 : oe_prev);
    oe_prev = exp_oe;
    chk(q_valid == ev[e], {seg, " R6 valid"}, DW'(q_valid), DW'(ev[e]));
    chk(q_data == (ev[e] ? ed[e] : '0), {seg, " R2 R9 R5 data"}, q_data, ev[e] ? ed[e] : '0);
    chk(rd_oe == exp_oe, {seg, " R7 oe"}, DW'(rd_oe), DW'(exp_oe));
    e++;
  endtask

  task automatic run_lat(input logic lat);
    do_reset(lat);
    // R3: requests on two consecutive rising-phase edges
    for (int i = 0; i < 40; i++) step((e % 8) < 4, AW'($urandom), "R3");
    // R1: requests only on falling-phase beats
    for (int i = 0; i < 20; i++) step(e % 2 == 1, AW'($urandom), "R1");
    // R4: select held high
    for (int i = 0; i < 60; i++) step(1'b1, AW'($urandom), "R4");
    // random mix
    for (int i = 0; i < 200; i++) step(1'($urandom), AW'($urandom), "R1 R3 R5");
    // drain, release check
    for (int i = 0; i < 12; i++) step(1'b0, '0, "R7");
  endtask

  initial begin
    errors = 0; checks = 0; done = 1'b0;
    void'($urandom(32'h1357));
    // R9: fill every word through the load port
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = (AW+2)'(i); ld_data = DW'($urandom);
      sh[i] = ld_data;
    end
    @(negedge clk);
    ld_en = 1'b0;
    run_lat(1'b1);
    run_lat(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule